// File: doc/BRIEF.md
# DMA Channel Trigger Controller

This block is the per-channel control logic of a small DMA engine. It holds one 32-bit channel configuration word and decides, from peripheral strobes, a software strobe and an event input, when the channel may ask the arbiter for the bus. The configuration sets how much work one trigger buys: a single beat, a whole block, or a full transaction. It also sets which peripheral strobe counts as a trigger, the channel's arbitration level, and how the event input is used. The event input can start a transfer, join a peripheral strobe to make a conditional trigger, suspend or resume the channel, or cancel the next end-of-block suspend.

The datapath reports beat, block and transaction completion with one-cycle pulses. It also raises a pulse when a finished block carries a suspend action. The block answers with a request and its level, a suspended flag and an optional completion event pulse. Most configuration fields are frozen while the channel is enabled. Only the arbitration level can be changed at any time.

Top module: `dma_trig_ctrl`

## Requirements
- R1: After reset the configuration word reads 0 and `req`, `suspended` and `evt_out` are 0. The field positions are: trigger action [23:22], trigger source [13:8], level [6:5], event-output enable [4], event-input enable [3], event action [2:0]. All other bits read 0, so writing all ones with the channel disabled reads back 0x00C03F7F.
- R2: While `ch_en` is 1, a write changes only the level bits [6:5] and leaves every other field unchanged. `req_lvl` always equals the stored level.
- R3: With trigger source s, a strobe on `periph_trig[s]` raises `req` one cycle later, and strobes on other indices do nothing. Source 0 and the reserved sources 1, 44, 62 and 63 never fire.
- R4: The trigger action sets the scope of one trigger. Action 2 allows one beat, and any done pulse clears the request. Action 0, and the reserved action 1, allow one block, and block-done or transaction-done clears it. Action 3 allows a whole transaction, and only transaction-done clears it.
- R5: A trigger that arrives while a trigger is pending is lost. This includes a trigger in the same cycle as the done pulse that ends the pending trigger.
- R6: `sw_trig` triggers the enabled channel under any configuration.
- R7: `evt_in` has no effect when event-input enable is 0, or when the event action is 0 or 7.
- R8: Event action 1 makes each event a plain trigger.
- R9: Event actions 2 and 3 require both an event and a strobe from the selected peripheral. Each is latched until the pair is complete, and then both are consumed. Action 2 uses the configured scope. Action 3 always allows one block.
- R10: Event action 4 suspends the channel. While suspended, `req` is 0 but the pending trigger is kept.
- R11: Event action 5 clears the suspended state, so a kept trigger requests again. `blk_susp` suspends the channel unless a skip armed by event action 6 is present. The skip is consumed by the next `blk_susp`.
- R12: With event-output enable set, `evt_out` pulses for one cycle, one cycle after the done pulse that ends a pending trigger. With it clear, `evt_out` stays 0.
- R13: Clearing `ch_en` clears the pending trigger, the suspended state, the skip flag and the conditional latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_data | input | 32 | Configuration write value |
| ch_en | input | 1 | Channel enable |
| periph_trig | input | NUM_PERIPH | Peripheral trigger strobes, one per source index |
| sw_trig | input | 1 | Software trigger strobe |
| evt_in | input | 1 | Event input strobe |
| beat_done | input | 1 | Datapath finished a beat |
| block_done | input | 1 | Datapath finished a block |
| xfer_done | input | 1 | Datapath finished the transaction |
| blk_susp | input | 1 | Finished block requests a suspend |
| rd_data | output | 32 | Current configuration word |
| req | output | 1 | Channel requests the bus |
| req_lvl | output | 2 | Arbitration level of the request |
| suspended | output | 1 | Channel is suspended |
| evt_out | output | 1 | Completion event pulse |

## Verification
The sensitive overlap is a done pulse that ends the pending trigger arriving in the same cycle as a fresh trigger. The bench drives `block_done` together with `sw_trig` and expects `req` low afterwards, because the new trigger is lost. A second overlap has both halves of a conditional trigger, the peripheral strobe and the event, arrive in one cycle. That pair must fire at once, and the bench checks that `req` rises on the next cycle.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
   localparam int REG_W    = 32;
   localparam int SRC_W    = 6;
   localparam int LVL_W    = 2;
   localparam int TA_LSB   = 22;
   localparam int SRC_LSB  = 8;
   localparam int LVL_LSB  = 5;
   localparam int EVOE_BIT = 4;
   localparam int EVIE_BIT = 3;
   localparam int EACT_LSB = 0;

   typedef enum logic [1:0] {TA_BLOCK = 2'd0, TA_RSVD = 2'd1, TA_BEAT = 2'd2, TA_XFER = 2'd3} trig_act_e;
   typedef enum logic [2:0] {EA_NONE = 3'd0, EA_TRIG = 3'd1, EA_CTRIG = 3'd2, EA_CBLOCK = 3'd3,
                             EA_SUSP = 3'd4, EA_RESUME = 3'd5, EA_SKIP = 3'd6, EA_RSVD = 3'd7} evt_act_e;
   typedef enum logic [1:0] {SC_BEAT = 2'd0, SC_BLOCK = 2'd1, SC_XFER = 2'd2} scope_e;

   typedef struct packed {
      trig_act_e        act;
      logic [SRC_W-1:0] src;
      logic [LVL_W-1:0] lvl;
      logic             evoe;
      logic             evie;
      evt_act_e         eact;
   } cfg_t;

   function automatic logic src_reserved(input int unsigned s);
      return (s == 1) || (s == 44) || (s >= 62);
   endfunction
endpackage

// File: rtl/dtc_cfg_reg.sv
module dtc_cfg_reg
   import dtc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   input  logic             ch_en,
   output cfg_t             cfg,
   output logic [REG_W-1:0] rd_word
);
   localparam logic [REG_W-1:0] FIELD_MASK = 32'h00C0_3F7F;

   logic [REG_W-1:0] wr_keep;
   assign wr_keep = wr_data & FIELD_MASK;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg <= '0;
      end else if (wr_en) begin
         cfg.lvl <= wr_keep[LVL_LSB +: LVL_W];
         if (!ch_en) begin
            cfg.act  <= trig_act_e'(wr_keep[TA_LSB +: 2]);
            cfg.src  <= wr_keep[SRC_LSB +: SRC_W];
            cfg.evoe <= wr_keep[EVOE_BIT];
            cfg.evie <= wr_keep[EVIE_BIT];
            cfg.eact <= evt_act_e'(wr_keep[EACT_LSB +: 3]);
         end
      end
   end

   always_comb begin
      rd_word                       = '0;
      rd_word[TA_LSB +: 2]          = cfg.act;
      rd_word[SRC_LSB +: SRC_W]     = cfg.src;
      rd_word[LVL_LSB +: LVL_W]     = cfg.lvl;
      rd_word[EVOE_BIT]             = cfg.evoe;
      rd_word[EVIE_BIT]             = cfg.evie;
      rd_word[EACT_LSB +: 3]        = cfg.eact;
   end
endmodule

// File: rtl/dtc_src_sel.sv
module dtc_src_sel
   import dtc_pkg::*;
#(
   parameter int NUM_PERIPH = 64
) (
   input  logic [SRC_W-1:0]      src,
   input  logic [NUM_PERIPH-1:0] strobes,
   output logic                  hit
);
   logic [NUM_PERIPH-1:0] hit_v;

   for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_src
      localparam logic USABLE = (i != 0) && !src_reserved(i);
      assign hit_v[i] = USABLE & strobes[i] & (src == SRC_W'(i));
   end

   assign hit = |hit_v;
endmodule

// File: rtl/dtc_run_ctl.sv
module dtc_run_ctl
   import dtc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      ch_en,
   input  trig_act_e ta,
   input  evt_act_e  eact,
   input  logic      evie,
   input  logic      evoe,
   input  logic      per_hit,
   input  logic      sw_trig,
   input  logic      evt_in,
   input  logic      beat_done,
   input  logic      block_done,
   input  logic      xfer_done,
   input  logic      blk_susp,
   output logic      req,
   output logic      suspended,
   output logic      evt_out
);
   logic   pend_q, susp_q, skip_q, per_seen_q, evt_seen_q, eo_q;
   scope_e scope_q, scope_new;
   logic   evt_ok, cond_mode, per_seen_d, evt_seen_d, cond_fire, direct, trig;
   logic   done_hit, end_hit;

   always_comb begin
      evt_ok     = ch_en & evie & evt_in;
      cond_mode  = evie & ((eact == EA_CTRIG) | (eact == EA_CBLOCK));
      per_seen_d = per_seen_q | (per_hit & cond_mode);
      evt_seen_d = evt_seen_q | (evt_ok & cond_mode);
      cond_fire  = cond_mode & per_seen_d & evt_seen_d;
      direct     = sw_trig | (per_hit & ~cond_mode) | (evt_ok & (eact == EA_TRIG));
      trig       = ch_en & (direct | cond_fire);

      unique case (ta)
         TA_BEAT: scope_new = SC_BEAT;
         TA_XFER: scope_new = SC_XFER;
         default: scope_new = SC_BLOCK;
      endcase
      if (cond_fire && eact == EA_CBLOCK) scope_new = SC_BLOCK;

      unique case (scope_q)
         SC_BEAT:  done_hit = beat_done | block_done | xfer_done;
         SC_XFER:  done_hit = xfer_done;
         default:  done_hit = block_done | xfer_done;
      endcase
      end_hit = pend_q & done_hit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q     <= 1'b0;
         susp_q     <= 1'b0;
         skip_q     <= 1'b0;
         per_seen_q <= 1'b0;
         evt_seen_q <= 1'b0;
         eo_q       <= 1'b0;
         scope_q    <= SC_BLOCK;
      end else if (!ch_en) begin
         pend_q     <= 1'b0;
         susp_q     <= 1'b0;
         skip_q     <= 1'b0;
         per_seen_q <= 1'b0;
         evt_seen_q <= 1'b0;
         eo_q       <= 1'b0;
      end else begin
         if (end_hit) begin
            pend_q <= 1'b0;
         end else if (!pend_q && trig) begin
            pend_q  <= 1'b1;
            scope_q <= scope_new;
         end
         per_seen_q <= cond_mode & ~cond_fire & per_seen_d;
         evt_seen_q <= cond_mode & ~cond_fire & evt_seen_d;
         if (evt_ok && eact == EA_RESUME)     susp_q <= 1'b0;
         else if (evt_ok && eact == EA_SUSP)  susp_q <= 1'b1;
         else if (blk_susp && !skip_q)        susp_q <= 1'b1;
         if (evt_ok && eact == EA_SKIP)       skip_q <= 1'b1;
         else if (blk_susp)                   skip_q <= 1'b0;
         eo_q <= end_hit & evoe;
      end
   end

   assign req       = pend_q & ~susp_q;
   assign suspended = susp_q;
   assign evt_out   = eo_q;
endmodule

// File: rtl/dma_trig_ctrl.sv
module dma_trig_ctrl
   import dtc_pkg::*;
#(
   parameter int NUM_PERIPH = 64
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [31:0]           wr_data,
   input  logic                  ch_en,
   input  logic [NUM_PERIPH-1:0] periph_trig,
   input  logic                  sw_trig,
   input  logic                  evt_in,
   input  logic                  beat_done,
   input  logic                  block_done,
   input  logic                  xfer_done,
   input  logic                  blk_susp,
   output logic [31:0]           rd_data,
   output logic                  req,
   output logic [1:0]            req_lvl,
   output logic                  suspended,
   output logic                  evt_out
);
   cfg_t cfg;
   logic per_hit;

   dtc_cfg_reg u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .ch_en   (ch_en),
      .cfg     (cfg),
      .rd_word (rd_data)
   );

   dtc_src_sel #(.NUM_PERIPH(NUM_PERIPH)) u_sel (
      .src     (cfg.src),
      .strobes (periph_trig),
      .hit     (per_hit)
   );

   dtc_run_ctl u_run (
      .clk        (clk),
      .rst_n      (rst_n),
      .ch_en      (ch_en),
      .ta         (cfg.act),
      .eact       (cfg.eact),
      .evie       (cfg.evie),
      .evoe       (cfg.evoe),
      .per_hit    (per_hit),
      .sw_trig    (sw_trig),
      .evt_in     (evt_in),
      .beat_done  (beat_done),
      .block_done (block_done),
      .xfer_done  (xfer_done),
      .blk_susp   (blk_susp),
      .req        (req),
      .suspended  (suspended),
      .evt_out    (evt_out)
   );

   assign req_lvl = cfg.lvl;
endmodule

// File: rtl/dtc_checks.sv
module dtc_checks #(
   parameter int NUM_PERIPH = 64
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  wr_en,
   input logic [31:0]           wr_data,
   input logic                  ch_en,
   input logic [NUM_PERIPH-1:0] periph_trig,
   input logic                  sw_trig,
   input logic                  evt_in,
   input logic [31:0]           rd_data,
   input logic                  req,
   input logic [1:0]            req_lvl,
   input logic                  suspended,
   input logic                  evt_out
);
   localparam logic [31:0] LVL_BITS  = 32'h0000_0060;
   localparam logic [31:0] PROT_BITS = 32'h00C0_3F1F;

   initial begin
      if (NUM_PERIPH < 1 || NUM_PERIPH > 64)
         $error("NUM_PERIPH must lie in 1..64");
   end

   AST_LVL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ((rd_data & LVL_BITS) == ($past(wr_data) & LVL_BITS)) && (req_lvl == rd_data[6:5])); // R2

   AST_PROT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_en && wr_en) |=> ((rd_data & PROT_BITS) == $past(rd_data & PROT_BITS))); // R2

   AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req) |-> $past(sw_trig || evt_in || (|periph_trig))); // R3

   AST_SUSP_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_en && evt_in && rd_data[3] && rd_data[2:0] == 3'd4) |=> (!req && suspended)); // R10

   AST_EVT_OUT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      evt_out |=> !evt_out); // R12

   AST_EVT_OUT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      evt_out |-> rd_data[4]); // R12

   AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_en |=> (!req && !suspended && !evt_out)); // R13
endmodule

bind dma_trig_ctrl dtc_checks #(.NUM_PERIPH(NUM_PERIPH)) u_chk (.*);

// File: tb/dma_trig_ctrl_test.sv
module dma_trig_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int NP = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [31:0]   wr_data = '0;
   logic          ch_en = 1'b0;
   logic [NP-1:0] periph_trig = '0;
   logic          sw_trig = 1'b0, evt_in = 1'b0;
   logic          beat_done = 1'b0, block_done = 1'b0, xfer_done = 1'b0, blk_susp = 1'b0;
   logic [31:0]   rd_data;
   logic          req, suspended, evt_out;
   logic [1:0]    req_lvl;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;

   dma_trig_ctrl #(.NUM_PERIPH(NP)) uut (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input longint act, input longint exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] word(input int ta, input int src, input int lvl,
                                        input int evoe, input int evie, input int eact);
      return (32'(ta) << 22) | (32'(src) << 8) | (32'(lvl) << 5) |
             (32'(evoe) << 4) | (32'(evie) << 3) | 32'(eact);
   endfunction

   task automatic setup(input logic [31:0] w);
      ch_en = 1'b0; step;
      wr_en = 1'b1; wr_data = w; step;
      wr_en = 1'b0; ch_en = 1'b1; step;
   endtask

   task automatic p_sw();    sw_trig = 1;    step; sw_trig = 0;    endtask
   task automatic p_evt();   evt_in = 1;     step; evt_in = 0;     endtask
   task automatic p_beat();  beat_done = 1;  step; beat_done = 0;  endtask
   task automatic p_blk();   block_done = 1; step; block_done = 0; endtask
   task automatic p_xfer();  xfer_done = 1;  step; xfer_done = 0;  endtask
   task automatic p_bsus();  blk_susp = 1;   step; blk_susp = 0;   endtask
   task automatic p_per(input int i); periph_trig[i] = 1; step; periph_trig = '0; endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) step;
      rst_n = 1'b1;
      step;
      // R1 reset state
      chk("R1 reset word", rd_data, 0);
      chk("R1 reset req", req, 0);
      chk("R1 reset suspended", suspended, 0);
      chk("R1 reset evt_out", evt_out, 0);
      wr_en = 1; wr_data = 32'hFFFF_FFFF; step; wr_en = 0;
      chk("R1 field layout", rd_data, 32'h00C0_3F7F);

      // R2 protection while enabled
      wr_en = 1; wr_data = 32'h0; step; wr_en = 0;
      ch_en = 1; step;
      wr_en = 1; wr_data = 32'hFFFF_FFFF; step; wr_en = 0;
      chk("R2 only level written", rd_data, 32'h60);
      chk("R2 req_lvl follows", req_lvl, 3);
      wr_en = 1; wr_data = word(0, 0, 1, 0, 0, 0); step; wr_en = 0;
      chk("R2 level lowered", req_lvl, 1);

      // R3 sweep of every source value
      for (int s = 0; s < NP; s++) begin
         automatic bit usable = (s != 0) && (s != 1) && (s != 44) && (s < 62);
         setup(word(0, s, 0, 0, 0, 0));
         p_per(s ^ 1);
         chk($sformatf("R3 other index src %0d", s), req, 0);
         p_per(s);
         chk($sformatf("R3 selected src %0d", s), req, usable);
         p_blk();
         chk($sformatf("R3 cleared src %0d", s), req, 0);
      end

      // R4 scope per trigger action, R6 software trigger
      for (int ta = 0; ta < 4; ta++) begin
         setup(word(ta, 0, 0, 0, 0, 0));
         p_sw();
         chk($sformatf("R6 sw trigger ta %0d", ta), req, 1);
         p_beat();
         chk($sformatf("R4 after beat ta %0d", ta), req, ta != 2);
         p_blk();
         chk($sformatf("R4 after block ta %0d", ta), req, ta == 3);
         p_xfer();
         chk($sformatf("R4 after xfer ta %0d", ta), req, 0);
      end

      // R5 lost triggers
      setup(word(0, 0, 0, 0, 0, 0));
      p_sw(); p_sw();
      p_blk();
      chk("R5 trigger while pending lost", req, 0);
      p_sw();
      sw_trig = 1; block_done = 1; step; sw_trig = 0; block_done = 0;
      chk("R5 trigger with done lost", req, 0);

      // R12 event output
      setup(word(2, 0, 0, 1, 0, 0));
      p_sw(); p_beat();
      chk("R12 evt_out pulse", evt_out, 1);
      step;
      chk("R12 evt_out one cycle", evt_out, 0);
      setup(word(2, 0, 0, 0, 0, 0));
      p_sw(); p_beat();
      chk("R12 evt_out disabled", evt_out, 0);

      // R7 ignored events, R8 plain event trigger
      setup(word(0, 0, 0, 0, 0, 1));
      p_evt();
      chk("R7 event input disabled", req, 0);
      setup(word(0, 0, 0, 0, 1, 0));
      p_evt();
      chk("R7 action 0", req, 0);
      setup(word(0, 0, 0, 0, 1, 7));
      p_evt();
      chk("R7 action 7", req, 0);
      setup(word(0, 0, 0, 0, 1, 1));
      p_evt();
      chk("R8 event trigger", req, 1);

      // R9 conditional triggers
      setup(word(2, 5, 0, 0, 1, 2));
      p_per(5);
      chk("R9 strobe alone", req, 0);
      p_evt();
      chk("R9 pair complete", req, 1);
      p_beat();
      chk("R9 beat scope", req, 0);
      periph_trig[5] = 1; evt_in = 1; step; periph_trig = '0; evt_in = 0;
      chk("R9 pair same cycle", req, 1);
      setup(word(2, 5, 0, 0, 1, 3));
      p_evt();
      chk("R9 event alone", req, 0);
      p_per(5);
      chk("R9 block pair", req, 1);
      p_beat();
      chk("R9 block scope holds", req, 1);
      p_blk();
      chk("R9 block scope ends", req, 0);

      // R10 suspend by event
      setup(word(0, 0, 0, 0, 1, 4));
      p_sw(); p_evt();
      chk("R10 suspended", suspended, 1);
      chk("R10 req held low", req, 0);
      // R13 disable clears
      ch_en = 0; step; ch_en = 1; step;
      chk("R13 suspend cleared", suspended, 0);
      chk("R13 pending cleared", req, 0);
      setup(word(0, 5, 0, 0, 1, 2));
      p_per(5);
      ch_en = 0; step; ch_en = 1; step;
      p_evt();
      chk("R13 latch cleared", req, 0);

      // R11 resume and skip
      setup(word(0, 0, 0, 0, 1, 5));
      p_sw(); p_bsus();
      chk("R11 block suspend", suspended, 1);
      chk("R10 pending kept low", req, 0);
      p_evt();
      chk("R11 resume", suspended, 0);
      chk("R11 request returns", req, 1);
      setup(word(0, 0, 0, 0, 1, 6));
      p_evt(); p_bsus();
      chk("R11 skip cancels", suspended, 0);
      p_bsus();
      chk("R11 skip consumed", suspended, 1);

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule